// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one parallel data word at a time into a serial frame on a single output line. The line rests at logic high. A frame is one low start bit, then 5 to 9 data bits with the least significant bit first, then an optional even or odd parity bit, and then one or two high stop bits. Static configuration inputs choose the frame shape and the timing mode. The block reads those inputs, together with the data word, when it accepts the word, and it keeps using those values until the frame is finished.

Words come in over a valid/ready handshake. The block raises ready only while it is idle, so it takes one word per frame. In asynchronous mode a strobe from an external baud generator moves the frame forward by one bit period per strobe. In synchronous mode an external serial clock sets the bit timing instead: the output changes after the rising serial clock edge when the edge-polarity input is 0, and after the falling edge when it is 1. After the block accepts a word, it waits for the first active step before it drives the start bit. This keeps every bit, including the start bit, exactly one step interval long.

Top module: `sft_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, the serial output is high and ready is high.
- R2: A frame is driven in this order: start bit 0, the data bits least significant bit first, the parity bit if enabled, then the stop bits at 1. Each bit lasts exactly one step interval, and the output changes only in the clock cycle after a step.
- R3: Stop-bit select 0 sends one stop bit and select 1 sends two. Ready rises only after the last stop bit has lasted one full step interval.
- R4: Parity code 2'b10 appends even parity, which is the XOR of the data bits actually sent. Code 2'b11 appends odd parity, which is that XOR inverted. Code 2'b00 sends no parity bit.
- R5: The reserved parity code 2'b01 sends no parity bit.
- R6: Size codes 3'b000, 3'b001, 3'b010 and 3'b011 send 5, 6, 7 and 8 data bits, and code 3'b111 sends 9. Data bits above the chosen size are neither sent nor counted in the parity.
- R7: The reserved size codes 3'b100, 3'b101 and 3'b110 send 8 data bits.
- R8: A word is accepted on a clock edge where valid and ready are both high. Ready is low from acceptance until the frame ends. The data and all configuration inputs are captured at acceptance, and later changes to them have no effect on the frame in progress.
- R9: In asynchronous mode (sync select 0), each baud strobe is one step. The serial clock and the edge-polarity input have no effect.
- R10: In synchronous mode (sync select 1), a step is a rising serial clock edge when polarity is 0, or a falling edge when polarity is 1. The baud strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sync | input | 1 | 0: asynchronous timing from baud strobe, 1: synchronous timing from serial clock |
| cfg_edge_pol | input | 1 | Synchronous mode only: 0 changes output after rising serial clock edge, 1 after falling edge |
| cfg_parity | input | 2 | 00 none, 01 reserved (none), 10 even, 11 odd |
| cfg_two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| cfg_size | input | 3 | Data bit count code: 000-011 give 5-8, 111 gives 9, others give 8 |
| in_valid | input | 1 | Data word offered |
| in_ready | output | 1 | Block idle and able to accept a word |
| in_data | input | 9 | Data word, bit 0 sent first |
| baud_tick | input | 1 | One-cycle bit-period strobe for asynchronous mode |
| sclk | input | 1 | Serial clock for synchronous mode, sampled by clk |
| txd | output | 1 | Serial data output, idles high |

## Verification
The assertions assume that the serial clock is a level already synchronous to clk, and that each of its levels lasts at least one clk cycle, so every edge shows up as a one-cycle difference between successive samples. They also assume reset is held for at least two cycles, so the two-deep history used by the edge checks is defined. The stimulus changes every input only on the falling clk edge. It toggles the serial clock every three cycles and pulses the baud strobe every four cycles, in both modes, so the unused timing source is always active and its lack of effect is observed. A behavioural queue model in the bench predicts the output level and ready on every cycle, and both are compared against the model.

// File: rtl/sft_pkg.sv
package sft_pkg;

    localparam int DATA_W = 9;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic       sync;
        logic       pol;
        logic [1:0] par;
        logic       two_stop;
        logic [2:0] size;
    } frame_cfg_t;

    // Data bit count for a size code; reserved codes fall back to 8.
    function automatic logic [CNT_W-1:0] data_bits(input logic [2:0] code);
        logic [CNT_W-1:0] n;
        case (code)
            3'b000:  n = CNT_W'(5);
            3'b001:  n = CNT_W'(6);
            3'b010:  n = CNT_W'(7);
            3'b011:  n = CNT_W'(8);
            3'b111:  n = CNT_W'(9);
            default: n = CNT_W'(8);
        endcase
        return n;
    endfunction

    function automatic logic [DATA_W-1:0] size_mask(input logic [2:0] code);
        logic [DATA_W-1:0] m;
        logic [CNT_W-1:0]  n;
        n = data_bits(code);
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = (i < int'(n));
        end
        return m;
    endfunction

    // Only the upper parity code bit enables a parity bit; 01 is treated as off.
    function automatic logic parity_on(input logic [1:0] par);
        return par[1];
    endfunction

    function automatic logic parity_bit(input logic [DATA_W-1:0] d, input frame_cfg_t c);
        return (^(d & size_mask(c.size))) ^ c.par[0];
    endfunction

endpackage

// File: rtl/sft_step_gen.sv
module sft_step_gen (
    input  logic clk,
    input  logic sync_mode,
    input  logic edge_pol,
    input  logic sclk,
    input  logic baud_tick,
    output logic step
);
    logic sclk_prev;
    logic rise;
    logic fall;

    always_ff @(posedge clk) begin
        sclk_prev <= sclk;
    end

    assign rise = sclk & ~sclk_prev;
    assign fall = ~sclk & sclk_prev;

    always_comb begin
        if (sync_mode) begin
            step = edge_pol ? fall : rise;
        end else begin
            step = baud_tick;
        end
    end
endmodule

// File: rtl/sft_frame_seq.sv
module sft_frame_seq
    import sft_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  frame_cfg_t        cfg_in,
    output logic              in_ready,
    output logic              txd,
    output frame_cfg_t        held
);
    tx_state_e         st;
    logic [DATA_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic              stop_left;
    logic              par_q;
    logic              txd_q;

    assign in_ready = (st == ST_IDLE);
    assign txd      = txd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            txd_q     <= 1'b1;
            held      <= '0;
            sh        <= '0;
            cnt       <= '0;
            stop_left <= 1'b0;
            par_q     <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (in_valid) begin
                        held  <= cfg_in;
                        sh    <= in_data;
                        par_q <= parity_bit(in_data, cfg_in);
                        st    <= ST_ARM;
                    end
                end
                ST_ARM: begin
                    if (step) begin
                        txd_q <= 1'b0;
                        st    <= ST_START;
                    end
                end
                ST_START: begin
                    if (step) begin
                        txd_q <= sh[0];
                        sh    <= sh >> 1;
                        cnt   <= data_bits(held.size) - CNT_W'(1);
                        st    <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (step) begin
                        if (cnt == '0) begin
                            if (parity_on(held.par)) begin
                                txd_q <= par_q;
                                st    <= ST_PAR;
                            end else begin
                                txd_q     <= 1'b1;
                                stop_left <= held.two_stop;
                                st        <= ST_STOP;
                            end
                        end else begin
                            txd_q <= sh[0];
                            sh    <= sh >> 1;
                            cnt   <= cnt - CNT_W'(1);
                        end
                    end
                end
                ST_PAR: begin
                    if (step) begin
                        txd_q     <= 1'b1;
                        stop_left <= held.two_stop;
                        st        <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (step) begin
                        if (stop_left) begin
                            stop_left <= 1'b0;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R8: captured configuration stays fixed while a frame is in flight
    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && $past(!in_ready)) |-> $stable(held));

    // R6: data counter never exceeds the largest frame size
    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DATA) |-> (cnt < CNT_W'(DATA_W)));
endmodule

// File: rtl/sft_tx.sv
module sft_tx
    import sft_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_sync,
    input  logic              cfg_edge_pol,
    input  logic [1:0]        cfg_parity,
    input  logic              cfg_two_stop,
    input  logic [2:0]        cfg_size,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              baud_tick,
    input  logic              sclk,
    output logic              txd
);
    frame_cfg_t cfg_live;
    frame_cfg_t held;
    logic       step;

    always_comb begin
        cfg_live.sync     = cfg_sync;
        cfg_live.pol      = cfg_edge_pol;
        cfg_live.par      = cfg_parity;
        cfg_live.two_stop = cfg_two_stop;
        cfg_live.size     = cfg_size;
    end

    sft_step_gen u_step (
        .clk       (clk),
        .sync_mode (held.sync),
        .edge_pol  (held.pol),
        .sclk      (sclk),
        .baud_tick (baud_tick),
        .step      (step)
    );

    sft_frame_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .in_valid (in_valid),
        .in_data  (in_data),
        .cfg_in   (cfg_live),
        .in_ready (in_ready),
        .txd      (txd),
        .held     (held)
    );

    // R1: an idle block keeps the line high
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> txd);

    // R2: the output moves only after a step
    assert_change_on_step_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(txd) |-> $past(step));

    // R3: a frame always closes on a high stop level
    assert_stop_end_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(in_ready) |-> $past(txd));

    // R10: rising-edge timing in synchronous mode with polarity 0
    assert_rise_edge_R10: assert property (@(posedge clk) disable iff (rst)
        (held.sync && !held.pol && !$stable(txd)) |-> ($past(sclk) && !$past(sclk, 2)));

    // R10: falling-edge timing in synchronous mode with polarity 1
    assert_fall_edge_R10: assert property (@(posedge clk) disable iff (rst)
        (held.sync && held.pol && !$stable(txd)) |-> (!$past(sclk) && $past(sclk, 2)));
endmodule

// File: tb/sft_tx_bench.sv
module sft_tx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_sync = 1'b0;
    logic       cfg_edge_pol = 1'b0;
    logic [1:0] cfg_parity = 2'b00;
    logic       cfg_two_stop = 1'b0;
    logic [2:0] cfg_size = 3'b011;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [8:0] in_data = '0;
    logic       baud_tick = 1'b0;
    logic       sclk = 1'b0;
    logic       txd;

    int    checks = 0;
    int    failures = 0;
    int    cycles = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    sft_tx u_sft_tx (
        .clk          (clk),
        .rst          (rst),
        .cfg_sync     (cfg_sync),
        .cfg_edge_pol (cfg_edge_pol),
        .cfg_parity   (cfg_parity),
        .cfg_two_stop (cfg_two_stop),
        .cfg_size     (cfg_size),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_data      (in_data),
        .baud_tick    (baud_tick),
        .sclk         (sclk),
        .txd          (txd)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Free-running timing sources: both always active so the unused one is exercised
    int tick_cnt = 0;
    int sclk_cnt = 0;
    always @(negedge clk) begin
        tick_cnt  = tick_cnt + 1;
        baud_tick = (tick_cnt % 4 == 0);
        if (sclk_cnt == 2) begin
            sclk     = ~sclk;
            sclk_cnt = 0;
        end else begin
            sclk_cnt = sclk_cnt + 1;
        end
    end

    // Behavioural reference model
    bit m_q[$];
    bit m_idle = 1'b1;
    bit m_txd  = 1'b1;
    bit m_sync = 1'b0;
    bit m_pol  = 1'b0;
    bit m_prev = 1'b0;

    function automatic int size_of(input logic [2:0] code);
        if (code <= 3'd3) return 5 + int'(code);
        if (code == 3'd7) return 9;
        return 8;
    endfunction

    always @(posedge clk) begin
        bit stp;
        int nb;
        bit x;
        if (m_sync) stp = m_pol ? (!sclk && m_prev) : (sclk && !m_prev);
        else        stp = baud_tick;
        if (rst) begin
            m_q.delete();
            m_idle = 1'b1;
            m_txd  = 1'b1;
            m_sync = 1'b0;
            m_pol  = 1'b0;
        end else if (m_idle) begin
            if (in_valid) begin
                nb = size_of(cfg_size);
                m_q.push_back(1'b0);
                x = 1'b0;
                for (int i = 0; i < nb; i++) begin
                    m_q.push_back(in_data[i]);
                    x = x ^ in_data[i];
                end
                if (cfg_parity == 2'b10) m_q.push_back(x);
                if (cfg_parity == 2'b11) m_q.push_back(~x);
                m_q.push_back(1'b1);
                if (cfg_two_stop) m_q.push_back(1'b1);
                m_sync = cfg_sync;
                m_pol  = cfg_edge_pol;
                m_idle = 1'b0;
            end
        end else if (stp) begin
            if (m_q.size() > 0) m_txd = m_q.pop_front();
            else                m_idle = 1'b1;
        end
        m_prev = sclk;
    end

    task automatic check_bit(input logic act, input logic exp, input string what);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", cur_req, what, cycles, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        cycles = cycles + 1;
        if (chk_on && !rst && !done) begin
            check_bit(txd, m_txd, "txd");
            check_bit(in_ready, m_idle, "in_ready");
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        while (cycles < WATCHDOG) @(negedge clk);
        failures = failures + 1;
        $display("FAIL watchdog expired: actual=%0d expected<%0d", cycles, WATCHDOG);
        finish_run();
    end

    task automatic send(input logic [8:0] d, input logic [2:0] sz, input logic [1:0] p,
                        input logic two, input logic sy, input logic po,
                        input bit scramble, input string req);
        @(negedge clk);
        cur_req      = req;
        in_data      = d;
        cfg_size     = sz;
        cfg_parity   = p;
        cfg_two_stop = two;
        cfg_sync     = sy;
        cfg_edge_pol = po;
        in_valid     = 1'b1;
        do begin
            @(posedge clk);
            #1;
        end while (m_idle);
        @(negedge clk);
        in_valid = 1'b0;
        if (scramble) begin
            in_data      = ~d;
            cfg_size     = ~sz;
            cfg_parity   = ~p;
            cfg_two_stop = ~two;
            cfg_sync     = ~sy;
            cfg_edge_pol = ~po;
            in_valid     = 1'b1;
        end
        while (!m_idle) @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        check_bit(txd, 1'b1, "reset txd");
        check_bit(in_ready, 1'b1, "reset in_ready");
        chk_on = 1'b1;
        repeat (5) @(negedge clk);

        // R2 / R9: plain asynchronous frames, polarity input ignored
        send(9'h0A5, 3'b011, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        send(9'h03C, 3'b011, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
        // R3: two stop bits
        send(9'h0F0, 3'b011, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
        // R4: even and odd parity
        send(9'h06B, 3'b010, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        send(9'h015, 3'b000, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
        send(9'h000, 3'b011, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        // R5: reserved parity code
        send(9'h1FF, 3'b011, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
        // R6: sizes with upper bits set, 9-bit odd parity
        send(9'h1E3, 3'b000, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
        send(9'h1C9, 3'b001, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
        send(9'h1A2, 3'b111, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
        // R7: reserved size codes
        send(9'h155, 3'b100, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        send(9'h1AA, 3'b101, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        send(9'h133, 3'b110, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        // R8: inputs scrambled while the frame runs
        send(9'h0C3, 3'b011, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, "R8");
        send(9'h14E, 3'b111, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, "R8");
        // R10: synchronous mode, both polarities
        send(9'h05A, 3'b011, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, "R10");
        send(9'h0B7, 3'b010, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, "R10");
        send(9'h1F0, 3'b111, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, "R10");

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule